// File: doc/BRIEF.md
# Test-Report Command/Data Port Engine

This block is the hardware side of a small I/O-port window that guest software uses to report test progress. It has a write-only command port, a data port used in both directions, and a pair of timestamp ports. Software writes a 32-bit command code to the command port and then streams the payload through the data port as bytes, half-words or words. Each command kind expects its payload in a fixed layout. A per-command offset counter decides which field each write fills. When the payload is complete, the engine issues a one-cycle event to downstream logic. The event carries the command code, the payload length and the decoded fields.

The configuration query works the other way. After software writes the query selector, it reads a short little-endian response back through the data port. The response ends with a fixed "okay" tail word. A free-running 64-bit counter feeds the timestamp ports. Reading the low half latches the high half, so the two reads together form one coherent 64-bit value.

Accesses arrive on a valid/ready request channel. `acc_ready` is held high, so the engine takes one access in every cycle in which `acc_valid` is high and never applies back-pressure. Every accepted read returns its response on `rd_valid`/`rd_data` exactly one cycle later. The response channel cannot be stalled. The event output is a plain pulse with no handshake.

Top module: `test_report_port`

## Requirements
- R1: A command-port write is accepted only at size 2 or 4 bytes (`acc_size` 1 = half-word, 2 = word; 0 = byte, 3 = invalid). A half-word write is widened to `{16'hC0DE, data[15:0]}`. Byte and invalid-size command writes are ignored.
- R2: Every accepted command write clears the payload offset, the readable-response count, the text bytes, the value, the unit and the error count. After reset all event fields read zero.
- R3: String commands take only byte data writes. The string command codes are 0xC0DE0001, 0xC0DE0002, 0xC0DE0003, 0xC0DE0004, 0xC0DE0005 and 0xC0DE0006. Each nonzero byte is stored at the current offset and advances the offset. A zero byte raises an event with `evt_len` equal to the string length. Writes of any other size are dropped.
- R4: A string byte that arrives when the offset is already `STR_CAP-1` is dropped. This includes the terminating zero, so the longest string that can complete is `STR_CAP-2` characters.
- R5: The done commands (0xC0DE0010, 0xC0DE0011, 0xC0DE0012) take a 32-bit error count. It arrives either as one word write at offset 0 or as a half-word at offset 0 (low half) followed by a half-word at offset 2 (high half). Completion raises an event with `evt_len` = 4. Any other write is dropped.
- R6: The value command (0xC0DE0020) fills a 64-bit value at offsets 0..7 and a 32-bit unit at offsets 8..11. These are written as words at offsets 0/4/8 or as half-words at offsets 0/2/4/6/8/10. A half-word at offset 8 zeroes the upper unit half. Name bytes follow from offset 12 and are stored from text byte 0. A zero byte raises an event with `evt_len` equal to the name length.
- R7: When a value command completes, a unit of 0 or a unit of at least `UNIT_END` is replaced by 1 (the "none" unit).
- R8: A data write under the query command (0xC0DE0030) selects the response by selector:
  - selectors 0..`CFG_WORDS-1` return the matching configuration word (4 bytes);
  - the next `N_FLAGS` selectors return one configuration flag as a byte;
  - the selector after those returns the 16-bit threshold (2 bytes);
  - any other selector changes nothing.
- R9: After a query, each data-port read returns the next min(size, remaining) response bytes in little-endian order and advances the offset by that amount. A read at exactly the end of the response returns 0x600D7A11 and advances the offset by the read size. Any later read returns 0.
- R10: The following reads return 0xFFFFFFFF: a data-port read with no response pending, any command-port read, any read of a port other than 0..3, and any read with `acc_size` 3.
- R11: The timestamp ports (2 = low, 3 = high) answer only word reads; other read sizes return 0xFFFFFFFF. A low read returns `counter[31:0]` and latches `counter[63:32]`. A high read returns the latched half. Writes to these ports are ignored. The counter starts at `TS_RESET` and increments every cycle.
- R12: `acc_ready` is always 1. `rd_valid` is high in exactly the cycles that follow an accepted read, with the read's result on `rd_data`.
- R13: `evt_valid` is a one-cycle pulse, raised only in the cycle after a completing data write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Access request valid |
| acc_ready | output | 1 | Access accepted (always 1) |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_port | input | 3 | 0 command, 1 data, 2 timestamp low, 3 timestamp high |
| acc_size | input | 2 | 0 byte, 1 half-word, 2 word, 3 invalid |
| acc_wdata | input | 32 | Write data, right-aligned |
| rd_valid | output | 1 | Read response valid (one cycle after the read) |
| rd_data | output | 32 | Read response data |
| cfg_words | input | CFG_WORDS*32 | Configuration words, word i at bits 32i+31:32i |
| cfg_flags | input | N_FLAGS | Configuration flags |
| cfg_thresh | input | 16 | Configuration threshold |
| evt_valid | output | 1 | Completion event pulse |
| evt_cmd | output | 32 | Current command code |
| evt_len | output | LEN_W | Payload length of the completed command |
| evt_count | output | 32 | Error count (done commands) |
| evt_value | output | 64 | Value (value command) |
| evt_unit | output | 32 | Unit after range check |
| evt_text | output | STR_CAP*8 | String or name bytes, byte i at bits 8i+7:8i |

## Verification
The bench goes after the offset corner cases. One is a string that ends exactly one byte short of capacity against one that overflows. A design with an off-by-one bound would either raise an event it should not raise or miss the terminator. Another is the split error count, tested with a wrong-sized write between its halves. A design that does not drop that write would corrupt the count or complete too early. The read-back path is checked across byte, half-word and word reads, which exercises the partial-final-read trimming, the one-shot tail word and the zero fill after it; an error there shows up as a wrong `rd_data` pattern. The timestamp starts just below a 32-bit carry, so a design that does not latch the high half would return a high word that disagrees with the low word read before it.

// File: rtl/tr_pkg.sv
package tr_pkg;

  localparam logic [15:0] CMD_MAGIC_HI = 16'hC0DE;

  localparam logic [31:0] C_INIT        = 32'hC0DE_0001;
  localparam logic [31:0] C_SUB_NEW     = 32'hC0DE_0002;
  localparam logic [31:0] C_SUBSUB_NEW  = 32'hC0DE_0003;
  localparam logic [31:0] C_FAILED      = 32'hC0DE_0004;
  localparam logic [31:0] C_SKIPPED     = 32'hC0DE_0005;
  localparam logic [31:0] C_PRINT       = 32'hC0DE_0006;
  localparam logic [31:0] C_TERM        = 32'hC0DE_0010;
  localparam logic [31:0] C_SUB_DONE    = 32'hC0DE_0011;
  localparam logic [31:0] C_SUBSUB_DONE = 32'hC0DE_0012;
  localparam logic [31:0] C_VALUE       = 32'hC0DE_0020;
  localparam logic [31:0] C_QUERY       = 32'hC0DE_0030;

  localparam logic [31:0] OK_TAIL   = 32'h600D_7A11;
  localparam logic [31:0] UNIT_NONE = 32'd1;

  typedef enum logic [1:0] {SZ_B = 2'd0, SZ_H = 2'd1, SZ_W = 2'd2, SZ_X = 2'd3} size_e;
  typedef enum logic [2:0] {PT_CMD = 3'd0, PT_DATA = 3'd1, PT_TSLO = 3'd2, PT_TSHI = 3'd3} port_e;
  typedef enum logic [2:0] {K_NONE, K_STR, K_DONE, K_VAL, K_QRY} kind_e;

  function automatic kind_e kind_of(input logic [31:0] c);
    case (c)
      C_INIT, C_SUB_NEW, C_SUBSUB_NEW, C_FAILED, C_SKIPPED, C_PRINT: return K_STR;
      C_TERM, C_SUB_DONE, C_SUBSUB_DONE:                             return K_DONE;
      C_VALUE:                                                       return K_VAL;
      C_QUERY:                                                       return K_QRY;
      default:                                                       return K_NONE;
    endcase
  endfunction

endpackage

// File: rtl/tr_timestamp.sv
module tr_timestamp #(
  parameter logic [63:0] TS_RESET = 64'd0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        latch_hi,
  output logic [31:0] ts_lo,
  output logic [31:0] ts_hi
);
  logic [63:0] cnt_q;
  logic [31:0] hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= TS_RESET;
      hi_q  <= '0;
    end else begin
      cnt_q <= cnt_q + 64'd1;
      if (latch_hi) hi_q <= cnt_q[63:32];
    end
  end

  assign ts_lo = cnt_q[31:0];
  assign ts_hi = hi_q;
endmodule

// File: rtl/tr_query_sel.sv
module tr_query_sel #(
  parameter int CFG_WORDS = 10,
  parameter int N_FLAGS   = 3
) (
  input  logic [31:0]             sel,
  input  logic [CFG_WORDS*32-1:0] cfg_words,
  input  logic [N_FLAGS-1:0]      cfg_flags,
  input  logic [15:0]             cfg_thresh,
  output logic [31:0]             resp,
  output logic [2:0]              resp_len
);
  localparam int FLAG_BASE = CFG_WORDS;
  localparam int THR_SEL   = CFG_WORDS + N_FLAGS;

  always_comb begin
    resp     = '0;
    resp_len = 3'd0;
    for (int i = 0; i < CFG_WORDS; i++) begin
      if (sel == 32'(i)) begin
        resp     = cfg_words[i*32 +: 32];
        resp_len = 3'd4;
      end
    end
    for (int j = 0; j < N_FLAGS; j++) begin
      if (sel == 32'(FLAG_BASE + j)) begin
        resp     = {31'b0, cfg_flags[j]};
        resp_len = 3'd1;
      end
    end
    if (sel == 32'(THR_SEL)) begin
      resp     = {16'b0, cfg_thresh};
      resp_len = 3'd2;
    end
  end
endmodule

// File: rtl/tr_payload.sv
module tr_payload
  import tr_pkg::*;
#(
  parameter int STR_CAP  = 32,
  parameter int UNIT_END = 28,
  localparam int OFF_W   = $clog2(STR_CAP + 16),
  localparam int TIX_W   = $clog2(STR_CAP)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_wr,
  input  logic [31:0]          cmd_in,
  input  logic                 data_wr,
  input  logic                 data_rd,
  input  logic [1:0]           size,
  input  logic [31:0]          wdata,
  input  logic [31:0]          q_resp,
  input  logic [2:0]           q_len,
  output logic                 rd_mapped,
  output logic [31:0]          rd_word,
  output logic                 evt_valid,
  output logic [31:0]          evt_cmd,
  output logic [OFF_W-1:0]     evt_len,
  output logic [31:0]          evt_count,
  output logic [63:0]          evt_value,
  output logic [31:0]          evt_unit,
  output logic [STR_CAP*8-1:0] evt_text
);
  logic [31:0]      cmd_q, resp_q, unit_q, cnt_q;
  logic [63:0]      val_q;
  logic [OFF_W-1:0] off_q, len_q;
  logic [2:0]       rdcnt_q;
  logic             evt_q;
  logic [7:0]       txt_q [STR_CAP];

  kind_e            kind;
  logic [OFF_W-1:0] name_off, szb, rdc, rem, take;
  logic             str_room, name_room;
  logic [7:0]       byte_in;
  logic [15:0]      half_in;
  int               off_i;
  logic [31:0]      shifted;

  assign kind      = kind_of(cmd_q);
  assign byte_in   = wdata[7:0];
  assign half_in   = wdata[15:0];
  assign off_i     = int'(off_q);
  assign name_off  = off_q - OFF_W'(12);
  assign str_room  = off_i < STR_CAP - 1;
  assign name_room = (off_i >= 12) && (off_i - 12 < STR_CAP - 1);
  assign rdc       = OFF_W'(rdcnt_q);
  assign rem       = rdc - off_q;
  assign take      = (szb < rem) ? szb : rem;
  assign shifted   = resp_q >> (8 * off_i);
  assign rd_mapped = rdcnt_q != 3'd0;

  always_comb begin
    case (size)
      SZ_B:    szb = OFF_W'(1);
      SZ_H:    szb = OFF_W'(2);
      SZ_W:    szb = OFF_W'(4);
      default: szb = OFF_W'(0);
    endcase
  end

  always_comb begin
    rd_word = '0;
    if (off_q < rdc) begin
      for (int b = 0; b < 4; b++)
        if (OFF_W'(b) < take) rd_word[8*b +: 8] = shifted[8*b +: 8];
    end else if (off_q == rdc) begin
      rd_word = OK_TAIL;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0; resp_q <= '0; unit_q <= '0; cnt_q <= '0; val_q <= '0;
      off_q <= '0; len_q <= '0; rdcnt_q <= '0; evt_q <= 1'b0;
      for (int i = 0; i < STR_CAP; i++) txt_q[i] <= '0;
    end else begin
      evt_q <= 1'b0;
      if (cmd_wr) begin
        cmd_q <= cmd_in; off_q <= '0; rdcnt_q <= '0; resp_q <= '0;
        val_q <= '0; unit_q <= '0; cnt_q <= '0; len_q <= '0;
        for (int i = 0; i < STR_CAP; i++) txt_q[i] <= '0;
      end else if (data_wr) begin
        case (kind)
          K_STR: if (size == SZ_B && str_room) begin
            if (byte_in != 8'd0) begin
              txt_q[TIX_W'(off_q)] <= byte_in;
              off_q <= off_q + OFF_W'(1);
            end else begin
              evt_q <= 1'b1;
              len_q <= off_q;
            end
          end
          K_DONE: begin
            if (size == SZ_H && off_i == 0) begin
              cnt_q <= {16'b0, half_in};
              off_q <= OFF_W'(2);
            end else if (size == SZ_H && off_i == 2) begin
              cnt_q[31:16] <= half_in;
              evt_q <= 1'b1;
              len_q <= OFF_W'(4);
            end else if (size == SZ_W && off_i == 0) begin
              cnt_q <= wdata;
              evt_q <= 1'b1;
              len_q <= OFF_W'(4);
            end
          end
          K_VAL: begin
            if (size == SZ_W && (off_i == 0 || off_i == 4 || off_i == 8)) begin
              off_q <= off_q + OFF_W'(4);
              if (off_i == 0)      val_q[31:0]  <= wdata;
              else if (off_i == 4) val_q[63:32] <= wdata;
              else                 unit_q       <= wdata;
            end else if (size == SZ_H && off_i < 12 && !off_q[0]) begin
              off_q <= off_q + OFF_W'(2);
              if (off_i < 8)       val_q[16*off_q[2:1] +: 16] <= half_in;
              else if (off_i == 8) unit_q <= {16'b0, half_in};
              else                 unit_q[31:16] <= half_in;
            end else if (size == SZ_B && name_room) begin
              if (byte_in != 8'd0) begin
                txt_q[TIX_W'(name_off)] <= byte_in;
                off_q <= off_q + OFF_W'(1);
              end else begin
                evt_q <= 1'b1;
                len_q <= name_off;
                if (unit_q == 32'd0 || unit_q >= 32'(UNIT_END)) unit_q <= UNIT_NONE;
              end
            end
          end
          K_QRY: if (q_len != 3'd0) begin
            rdcnt_q <= q_len;
            resp_q  <= q_resp;
          end
          default: ;
        endcase
      end else if (data_rd && rd_mapped) begin
        if (off_q < rdc)       off_q <= off_q + take;
        else if (off_q == rdc) off_q <= off_q + szb;
      end
    end
  end

  for (genvar g = 0; g < STR_CAP; g++) begin : g_text
    assign evt_text[8*g +: 8] = txt_q[g];
  end

  assign evt_valid = evt_q;
  assign evt_cmd   = cmd_q;
  assign evt_len   = len_q;
  assign evt_count = cnt_q;
  assign evt_value = val_q;
  assign evt_unit  = unit_q;
endmodule

// File: rtl/test_report_port.sv
module test_report_port
  import tr_pkg::*;
#(
  parameter int          STR_CAP   = 32,
  parameter int          CFG_WORDS = 10,
  parameter int          N_FLAGS   = 3,
  parameter int          UNIT_END  = 28,
  parameter logic [63:0] TS_RESET  = 64'd0,
  localparam int         LEN_W     = $clog2(STR_CAP + 16)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    acc_valid,
  output logic                    acc_ready,
  input  logic                    acc_write,
  input  logic [2:0]              acc_port,
  input  logic [1:0]              acc_size,
  input  logic [31:0]             acc_wdata,
  output logic                    rd_valid,
  output logic [31:0]             rd_data,
  input  logic [CFG_WORDS*32-1:0] cfg_words,
  input  logic [N_FLAGS-1:0]      cfg_flags,
  input  logic [15:0]             cfg_thresh,
  output logic                    evt_valid,
  output logic [31:0]             evt_cmd,
  output logic [LEN_W-1:0]        evt_len,
  output logic [31:0]             evt_count,
  output logic [63:0]             evt_value,
  output logic [31:0]             evt_unit,
  output logic [STR_CAP*8-1:0]    evt_text
);
  logic        size_ok, is_rd, is_wr;
  logic        cmd_wr, data_wr, data_rd, ts_lo_rd;
  logic [31:0] cmd_in, q_resp, pl_word, ts_lo, ts_hi;
  logic [2:0]  q_len;
  logic        pl_mapped;

  assign acc_ready = 1'b1;
  assign size_ok   = acc_size != SZ_X;
  assign is_rd     = acc_valid && !acc_write && size_ok;
  assign is_wr     = acc_valid && acc_write && size_ok;
  assign cmd_wr    = is_wr && acc_port == PT_CMD && (acc_size == SZ_H || acc_size == SZ_W);
  assign cmd_in    = (acc_size == SZ_H) ? {CMD_MAGIC_HI, acc_wdata[15:0]} : acc_wdata;
  assign data_wr   = is_wr && acc_port == PT_DATA;
  assign data_rd   = is_rd && acc_port == PT_DATA;
  assign ts_lo_rd  = is_rd && acc_port == PT_TSLO && acc_size == SZ_W;

  tr_timestamp #(.TS_RESET(TS_RESET)) u_ts (
    .clk(clk), .rst_n(rst_n), .latch_hi(ts_lo_rd), .ts_lo(ts_lo), .ts_hi(ts_hi)
  );

  tr_query_sel #(.CFG_WORDS(CFG_WORDS), .N_FLAGS(N_FLAGS)) u_qsel (
    .sel(acc_wdata), .cfg_words(cfg_words), .cfg_flags(cfg_flags),
    .cfg_thresh(cfg_thresh), .resp(q_resp), .resp_len(q_len)
  );

  tr_payload #(.STR_CAP(STR_CAP), .UNIT_END(UNIT_END)) u_pl (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_in(cmd_in),
    .data_wr(data_wr), .data_rd(data_rd), .size(acc_size), .wdata(acc_wdata),
    .q_resp(q_resp), .q_len(q_len), .rd_mapped(pl_mapped), .rd_word(pl_word),
    .evt_valid(evt_valid), .evt_cmd(evt_cmd), .evt_len(evt_len),
    .evt_count(evt_count), .evt_value(evt_value), .evt_unit(evt_unit),
    .evt_text(evt_text)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= acc_valid && !acc_write;
      rd_data  <= 32'hFFFF_FFFF;
      if (is_rd) begin
        case (acc_port)
          PT_DATA: if (pl_mapped) rd_data <= pl_word;
          PT_TSLO: if (acc_size == SZ_W) rd_data <= ts_lo;
          PT_TSHI: if (acc_size == SZ_W) rd_data <= ts_hi;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/tr_port_chk.sv
module tr_port_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        acc_valid,
  input logic        acc_write,
  input logic [2:0]  acc_port,
  input logic [1:0]  acc_size,
  input logic        rd_valid,
  input logic [31:0] rd_data,
  input logic        evt_valid,
  input logic [31:0] evt_cmd,
  input logic [31:0] evt_count,
  input logic [63:0] evt_value
);
  // R12
  rd_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_write) |=> rd_valid);
  // R12
  rd_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(acc_valid && !acc_write));
  // R10
  cmd_read_ff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_write && acc_port == 3'd0) |=> (rd_data == 32'hFFFF_FFFF));
  // R11
  ts_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_write && (acc_port == 3'd2 || acc_port == 3'd3) && acc_size != 2'd2)
      |=> (rd_data == 32'hFFFF_FFFF));
  // R13
  evt_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |-> $past(acc_valid && acc_write && acc_port == 3'd1));
  // R1
  cmd_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_write && acc_port == 3'd0 && (acc_size == 2'd0 || acc_size == 2'd3))
      |=> $stable(evt_cmd));
  // R1
  cmd_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_write && acc_port == 3'd0 && acc_size == 2'd1)
      |=> (evt_cmd[31:16] == 16'hC0DE));
  // R2
  cmd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_write && acc_port == 3'd0 && (acc_size == 2'd1 || acc_size == 2'd2))
      |=> (evt_count == 32'd0 && evt_value == 64'd0 && !evt_valid));
endmodule

bind test_report_port tr_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
  .acc_port(acc_port), .acc_size(acc_size), .rd_valid(rd_valid), .rd_data(rd_data),
  .evt_valid(evt_valid), .evt_cmd(evt_cmd), .evt_count(evt_count), .evt_value(evt_value)
);

// File: tb/sim_test_report_port.sv
`timescale 1ns/1ps
module sim_test_report_port;
  localparam int          CAP  = 32;
  localparam int          NW   = 10;
  localparam int          NF   = 3;
  localparam int          UEND = 28;
  localparam logic [63:0] TSR  = 64'h0000_0001_FFFF_FFF0;
  localparam int          LW   = $clog2(CAP + 16);

  logic clk = 1'b0, rst_n = 1'b0;
  logic acc_valid = 1'b0, acc_write = 1'b0;
  logic [2:0] acc_port = '0;
  logic [1:0] acc_size = '0;
  logic [31:0] acc_wdata = '0;
  logic acc_ready, rd_valid, evt_valid;
  logic [31:0] rd_data, evt_cmd, evt_count, evt_unit;
  logic [LW-1:0] evt_len;
  logic [63:0] evt_value;
  logic [CAP*8-1:0] evt_text;
  logic [NW*32-1:0] cfg_words;
  logic [NF-1:0] cfg_flags = 3'b010;
  logic [15:0] cfg_thresh = 16'hBEEF;

  always #2 clk = ~clk;

  test_report_port #(.STR_CAP(CAP), .CFG_WORDS(NW), .N_FLAGS(NF), .UNIT_END(UEND), .TS_RESET(TSR)) u0 (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_ready(acc_ready),
    .acc_write(acc_write), .acc_port(acc_port), .acc_size(acc_size), .acc_wdata(acc_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .cfg_words(cfg_words), .cfg_flags(cfg_flags),
    .cfg_thresh(cfg_thresh), .evt_valid(evt_valid), .evt_cmd(evt_cmd), .evt_len(evt_len),
    .evt_count(evt_count), .evt_value(evt_value), .evt_unit(evt_unit), .evt_text(evt_text)
  );

  int checks = 0, fails = 0;
  bit done = 0;

  // behavioural reference state
  bit [63:0] ts_b;
  bit [31:0] m_hi, m_cmd, m_resp, m_unit, m_cnt;
  bit [63:0] m_val;
  int m_off, m_rdcnt;
  bit [7:0] m_txt [CAP];
  // expectations for the next compare
  bit e_rv, e_ev;
  bit [31:0] e_rd, e_cmd, e_cnt, e_unit;
  bit [63:0] e_val;
  int e_len;
  bit [CAP*8-1:0] e_txt;
  string e_req = "";

  always @(posedge clk) if (!rst_n) ts_b <= TSR; else ts_b <= ts_b + 64'd1;

  initial for (int i = 0; i < NW; i++) cfg_words[i*32 +: 32] = 32'hA500_0000 + 32'(i) * 32'h0101_0101;

  function automatic int kind(input bit [31:0] c);
    if (c >= 32'hC0DE_0001 && c <= 32'hC0DE_0006) return 1;
    if (c >= 32'hC0DE_0010 && c <= 32'hC0DE_0012) return 2;
    if (c == 32'hC0DE_0020) return 3;
    if (c == 32'hC0DE_0030) return 4;
    return 0;
  endfunction

  task automatic fire(input int len);
    e_ev = 1; e_len = len; e_cmd = m_cmd; e_cnt = m_cnt; e_unit = m_unit; e_val = m_val;
    for (int i = 0; i < CAP; i++) e_txt[8*i +: 8] = m_txt[i];
  endtask

  task automatic mdl_write(input bit [2:0] p, input int nb, input bit [31:0] d);
    int k;
    if (nb == 0) return;
    if (p == 0) begin
      if (nb >= 2) begin
        m_cmd = (nb == 2) ? {16'hC0DE, d[15:0]} : d;
        m_off = 0; m_rdcnt = 0; m_resp = 0; m_val = 0; m_unit = 0; m_cnt = 0;
        for (int i = 0; i < CAP; i++) m_txt[i] = 0;
      end
      return;
    end
    if (p != 1) return;
    k = kind(m_cmd);
    if (k == 1) begin
      if (nb == 1 && m_off < CAP - 1) begin
        if (d[7:0] != 0) begin m_txt[m_off] = d[7:0]; m_off++; end else fire(m_off);
      end
    end else if (k == 2) begin
      if (nb == 2 && m_off == 0) begin m_cnt = {16'h0, d[15:0]}; m_off = 2; end
      else if (nb == 2 && m_off == 2) begin m_cnt[31:16] = d[15:0]; fire(4); end
      else if (nb == 4 && m_off == 0) begin m_cnt = d; fire(4); end
    end else if (k == 3) begin
      if (nb == 4 && (m_off == 0 || m_off == 4 || m_off == 8)) begin
        if (m_off == 0) m_val[31:0] = d; else if (m_off == 4) m_val[63:32] = d; else m_unit = d;
        m_off += 4;
      end else if (nb == 2 && m_off < 12 && m_off % 2 == 0) begin
        if (m_off < 8) m_val[16*(m_off/2) +: 16] = d[15:0];
        else if (m_off == 8) m_unit = {16'h0, d[15:0]};
        else m_unit[31:16] = d[15:0];
        m_off += 2;
      end else if (nb == 1 && m_off >= 12 && m_off - 12 < CAP - 1) begin
        if (d[7:0] != 0) begin m_txt[m_off-12] = d[7:0]; m_off++; end
        else begin
          if (m_unit == 0 || m_unit >= UEND) m_unit = 1;
          fire(m_off - 12);
        end
      end
    end else if (k == 4) begin
      if (d < NW) begin m_resp = cfg_words[d*32 +: 32]; m_rdcnt = 4; end
      else if (d < NW + NF) begin m_resp = {31'b0, cfg_flags[d-NW]}; m_rdcnt = 1; end
      else if (d == NW + NF) begin m_resp = {16'h0, cfg_thresh}; m_rdcnt = 2; end
    end
  endtask

  task automatic mdl_read(input bit [2:0] p, input int nb);
    e_rv = 1; e_rd = 32'hFFFF_FFFF;
    if (nb == 0) return;
    if (p == 1 && m_rdcnt > 0) begin
      if (m_off < m_rdcnt) begin
        int t = (nb < m_rdcnt - m_off) ? nb : m_rdcnt - m_off;
        e_rd = 0;
        for (int b = 0; b < t; b++) e_rd[8*b +: 8] = m_resp[8*(m_off+b) +: 8];
        m_off += t;
      end else if (m_off == m_rdcnt) begin
        e_rd = 32'h600D_7A11; m_off += nb;
      end else e_rd = 0;
    end else if (p == 2 && nb == 4) begin
      e_rd = ts_b[31:0]; m_hi = ts_b[63:32];
    end else if (p == 3 && nb == 4) e_rd = m_hi;
  endtask

  task automatic chk(input bit ok, input string req, input string what, input bit [63:0] act, input bit [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic step(input bit v, input bit w, input bit [2:0] p, input bit [1:0] s, input bit [31:0] d, input string req);
    int nb;
    @(negedge clk);
    chk(rd_valid === e_rv && (!e_rv || rd_data === e_rd), e_req, "rd", {31'b0, rd_valid, rd_data}, {31'b0, e_rv, e_rd});
    chk(evt_valid === e_ev, e_req, "evt_valid", 64'(evt_valid), 64'(e_ev));
    if (e_ev) begin
      chk(evt_cmd === e_cmd && int'(evt_len) == e_len && evt_count === e_cnt, e_req, "evt cmd/len/count",
          {evt_cmd, 32'(evt_len)}, {e_cmd, 32'(e_len)});
      chk(evt_value === e_val && evt_unit === e_unit && evt_count === e_cnt, e_req, "evt value/unit/count",
          evt_value ^ 64'(evt_unit) ^ 64'(evt_count), e_val ^ 64'(e_unit) ^ 64'(e_cnt));
      chk(evt_text === e_txt, e_req, "evt_text", evt_text[63:0], e_txt[63:0]);
    end
    e_rv = 0; e_ev = 0; e_req = req;
    acc_valid = v; acc_write = w; acc_port = p; acc_size = s; acc_wdata = d;
    nb = (s == 0) ? 1 : (s == 1) ? 2 : (s == 2) ? 4 : 0;
    if (v && w) mdl_write(p, nb, d);
    else if (v) mdl_read(p, nb);
  endtask

  task automatic wr(input bit [2:0] p, input bit [1:0] s, input bit [31:0] d, input string req);
    step(1, 1, p, s, d, req);
  endtask
  task automatic rd(input bit [2:0] p, input bit [1:0] s, input string req);
    step(1, 0, p, s, 0, req);
  endtask
  task automatic idle(input string req);
    step(0, 0, 0, 0, 0, req);
  endtask
  task automatic str(input string t, input string req);
    for (int i = 0; i < t.len(); i++) wr(1, 0, 32'(t[i]), req);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    m_cmd = 0; m_off = 0; m_rdcnt = 0; m_resp = 0; m_val = 0; m_unit = 0; m_cnt = 0; m_hi = 0;
    for (int i = 0; i < CAP; i++) m_txt[i] = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    idle("R2");
    // R2 reset state
    chk(evt_cmd == 0 && evt_count == 0 && evt_value == 0 && evt_text == '0 && acc_ready,
        "R2", "reset fields", {evt_cmd, evt_count}, 64'd0);
    // R10 unmapped reads
    rd(1, 2, "R10"); rd(0, 2, "R10"); rd(5, 2, "R10"); rd(1, 3, "R10");
    // R1 half-word command widened, byte/invalid command writes ignored
    wr(0, 1, 32'hFFFF_0006, "R1");
    wr(0, 0, 32'h0000_0001, "R1");
    wr(0, 3, 32'hC0DE_0010, "R1");
    str("Hi", "R1"); wr(1, 0, 0, "R1");
    // R3 string with dropped wrong-size writes
    wr(0, 2, 32'hC0DE_0002, "R3");
    str("AB", "R3"); wr(1, 1, 32'h4343, "R3"); wr(1, 2, 32'h4444_4444, "R3");
    str("CD", "R3"); wr(1, 0, 0, "R3"); idle("R13");
    // R2 new command clears earlier text
    wr(0, 2, 32'hC0DE_0004, "R2"); str("X", "R2"); wr(1, 0, 0, "R2");
    // R4 longest string completes, one longer does not
    wr(0, 2, 32'hC0DE_0005, "R4");
    for (int i = 0; i < CAP - 2; i++) wr(1, 0, 32'h61 + 32'(i % 26), "R4");
    wr(1, 0, 0, "R4");
    wr(0, 2, 32'hC0DE_0003, "R4");
    for (int i = 0; i < CAP + 3; i++) wr(1, 0, 32'h41 + 32'(i % 26), "R4");
    wr(1, 0, 0, "R4"); idle("R4");
    // R5 done commands
    wr(0, 2, 32'hC0DE_0010, "R5"); wr(1, 2, 32'd7, "R5");
    wr(0, 1, 32'h0011, "R5"); wr(1, 1, 32'h1234, "R5"); wr(1, 2, 32'hDEAD_BEEF, "R5");
    wr(1, 0, 32'h55, "R5"); wr(1, 1, 32'h0005, "R5");
    wr(0, 2, 32'hC0DE_0012, "R5"); wr(1, 2, 32'h0000_0099, "R5"); idle("R13");
    // R6/R7 value command, word layout, valid unit
    wr(0, 2, 32'hC0DE_0020, "R6");
    wr(1, 2, 32'h1122_3344, "R6"); wr(1, 2, 32'h5566_7788, "R6"); wr(1, 2, 32'd27, "R7");
    str("ns", "R6"); wr(1, 0, 0, "R6");
    // R6/R7 half-word layout, unit zero
    wr(0, 2, 32'hC0DE_0020, "R6");
    wr(1, 1, 32'hAAAA, "R6"); wr(1, 1, 32'hBBBB, "R6"); wr(1, 1, 32'hCCCC, "R6");
    wr(1, 1, 32'hDDDD, "R6"); wr(1, 1, 32'h0000, "R7"); wr(1, 1, 32'h0000, "R7");
    str("k", "R6"); wr(1, 0, 0, "R7");
    // R7 unit at UNIT_END replaced
    wr(0, 2, 32'hC0DE_0020, "R7");
    wr(1, 2, 32'd1, "R7"); wr(1, 2, 32'd0, "R7"); wr(1, 2, 32'd28, "R7"); wr(1, 0, 0, "R7");
    // R8/R9 query word, tail, zeros
    wr(0, 2, 32'hC0DE_0030, "R8"); wr(1, 2, 32'd3, "R8");
    rd(1, 2, "R9"); rd(1, 2, "R9"); rd(1, 2, "R9"); rd(1, 0, "R9");
    wr(0, 2, 32'hC0DE_0030, "R8"); wr(1, 2, 32'd9, "R8");
    rd(1, 0, "R9"); rd(1, 2, "R9"); rd(1, 1, "R9"); rd(1, 1, "R9");
    wr(0, 2, 32'hC0DE_0030, "R8"); wr(1, 2, 32'd11, "R8"); rd(1, 2, "R8"); rd(1, 2, "R9");
    wr(0, 2, 32'hC0DE_0030, "R8"); wr(1, 2, 32'd13, "R8"); rd(1, 1, "R8"); rd(1, 1, "R9");
    wr(0, 2, 32'hC0DE_0030, "R8"); wr(1, 2, 32'd14, "R8"); rd(1, 2, "R10");
    // R11 timestamp latch across the 32-bit carry
    rd(2, 2, "R11"); rd(3, 2, "R11");
    for (int i = 0; i < 20; i++) idle("R11");
    rd(3, 2, "R11"); rd(2, 2, "R11"); wr(3, 2, 32'h1234_5678, "R11"); rd(3, 2, "R11");
    rd(2, 1, "R11"); rd(3, 0, "R11");
    // R12 back-to-back reads
    rd(2, 2, "R12"); rd(2, 2, "R12"); idle("R12"); idle("R12");
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule